// File: doc/BRIEF.md
# Per-Core Idle State Sequencer

This block sequences the idle power states of a configurable number of cores and of the uncore logic they share. Software on a core asks for an idle depth; the block halts that core, stops its clocks step by step and, at the deepest level, saves its state and removes its power. When an interrupt arrives for that core, the block brings it back in the reverse order. Each core has its own sequencer, so one core going idle or waking never changes the outputs of any other core.

A package sequencer watches every core. Only when every core sits fully power-gated, with no interrupt pending, does it stop the uncore logic, put the I/O into low power and stop the uncore clock grids. An interrupt for any core while the package is deep first brings back the uncore clocks and I/O, then the uncore logic, and only after that may the core begin its own wake-up.

Each save, restore and power ramp step ends on its done handshake or, if the handshake never arrives, after a programmable number of cycles. An interrupt during the entry to the deepest state cancels the entry from the step it has reached.

Core states (encoding on `core_state`): ACTIVE=0, LIGHT=1, CLKOFF=2, SAVING=3, GATING=4, GATED=5, UNGATING=6, RESTORING=7. Transitions: ACTIVE to LIGHT, CLKOFF or SAVING on a request; LIGHT and CLKOFF to ACTIVE on an interrupt; SAVING to GATING on step end, SAVING to ACTIVE on an interrupt (abort); GATING to GATED on step end, GATING to UNGATING on an interrupt (abort); GATED to UNGATING on an interrupt while the uncore is running; UNGATING to RESTORING and RESTORING to ACTIVE on step end. Package states: RUN, WAKE, DEEP. Transitions: RUN to DEEP when all cores are GATED and no interrupt is high; DEEP to WAKE on any interrupt; WAKE to RUN after one cycle.

Top module: `idle_ctrl`

## Requirements
- R1: After reset every core is ACTIVE (state code 0) with power, both clock groups and the pipeline enabled, and the package is RUN with uncore logic and uncore clocks enabled, I/O in normal power and `pkg_deep` low.
- R2: In ACTIVE, a request with depth code 1 moves the core to LIGHT (pipeline halted, main clocks off, remaining clocks on) and depth code 2 moves it to CLKOFF (all clocks off), one cycle later; depth code 0, a request made while the core's interrupt is high, and any request in a state other than ACTIVE are ignored.
- R3: Depth code 3 starts the deep entry: SAVING (save request high, clocks on, power on), then GATING (clocks off, power off), then GATED; each wait step ends in the cycle after its done input is seen high.
- R4: An interrupt in LIGHT or CLKOFF returns the core to ACTIVE one cycle later.
- R5: An interrupt in GATED runs the exit: UNGATING (power on, clocks off), then RESTORING (clocks on, restore request high), then ACTIVE; save and restore requests are never high together.
- R6: An interrupt seen in SAVING returns the core straight to ACTIVE; an interrupt seen in GATING moves it to UNGATING.
- R7: A transition on one core leaves every other core's state and outputs unchanged.
- R8: The package enters DEEP only when every core is GATED and no interrupt is high; in DEEP the uncore logic enable is low, I/O low-power is high and the uncore clock enable is low.
- R9: Any interrupt in DEEP gives one WAKE cycle (uncore clocks on, I/O normal, uncore logic still off) and then RUN; a GATED core leaves GATED only on a cycle after the package is back in RUN.
- R10: With no done handshake, each of SAVING, GATING, UNGATING and RESTORING lasts exactly `tmo_lim`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_lim | input | TW | Step timeout limit in cycles, minus one |
| idle_req | input | N | Per-core idle request strobe |
| idle_depth | input | 2*N | Per-core requested depth (0 none, 1 light, 2 clock-off, 3 gated) |
| irq | input | N | Per-core interrupt, held until the core is ACTIVE |
| save_done | input | N | Per-core state save complete |
| restore_done | input | N | Per-core state restore complete |
| pg_ack | input | N | Per-core power ramp complete |
| core_state | output | 3*N | Per-core state code |
| core_run | output | N | Per-core pipeline enable |
| clk_most_en | output | N | Per-core main clock group enable |
| clk_rest_en | output | N | Per-core remaining clock group enable |
| pwr_en | output | N | Per-core power gate enable (1 = powered) |
| save_req | output | N | Per-core state save request |
| restore_req | output | N | Per-core state restore request |
| unc_act_en | output | 1 | Uncore logic enable |
| io_lp | output | 1 | I/O low-power request |
| unc_clk_en | output | 1 | Uncore clock grid enable |
| pkg_deep | output | 1 | Package is in DEEP |

## Verification
On every cycle the assertions check the per-core output invariants (no clock without power, no running pipeline without clocks, save and restore exclusive), that the package is deep only with every core gated, that UNGATING is entered only from GATED or GATING, that a gated core leaves only while the uncore runs, and the uncore bring-up order on leaving DEEP. Only the bench scenarios show the exact step order and dwell times, the timeout count for each limit, the abort paths, the ignored requests, and that a wake on one core leaves the others untouched.

// File: rtl/idle_pkg.sv
package idle_pkg;
    typedef enum logic [2:0] {
        CS_ACT  = 3'd0,
        CS_C1   = 3'd1,
        CS_C3   = 3'd2,
        CS_SAVE = 3'd3,
        CS_GOFF = 3'd4,
        CS_C6   = 3'd5,
        CS_GON  = 3'd6,
        CS_REST = 3'd7
    } core_st_e;

    typedef enum logic [1:0] {
        PK_RUN  = 2'd0,
        PK_WAKE = 2'd1,
        PK_DEEP = 2'd2
    } pkg_st_e;

    localparam logic [1:0] DEPTH_NONE  = 2'd0;
    localparam logic [1:0] DEPTH_LIGHT = 2'd1;
    localparam logic [1:0] DEPTH_CLKOFF = 2'd2;
    localparam logic [1:0] DEPTH_GATED = 2'd3;
endpackage

// File: rtl/idle_core_seq.sv
module idle_core_seq
    import idle_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [1:0]    depth,
    input  logic          irq,
    input  logic          unc_ready,
    input  logic          save_done,
    input  logic          restore_done,
    input  logic          pg_ack,
    input  logic [TW-1:0] tmo_lim,
    output core_st_e      state,
    output logic          run,
    output logic          clk_most_en,
    output logic          clk_rest_en,
    output logic          pwr_en,
    output logic          save_req,
    output logic          restore_req
);
    core_st_e      state_q, state_d;
    logic [TW-1:0] cnt_q;
    logic          step_end;

    assign step_end = (cnt_q >= tmo_lim);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_ACT: begin
                if (req && !irq) begin
                    if (depth == DEPTH_LIGHT)       state_d = CS_C1;
                    else if (depth == DEPTH_CLKOFF) state_d = CS_C3;
                    else if (depth == DEPTH_GATED)  state_d = CS_SAVE;
                end
            end
            CS_C1, CS_C3: if (irq) state_d = CS_ACT;
            CS_SAVE: begin
                if (irq)                         state_d = CS_ACT;
                else if (save_done || step_end)  state_d = CS_GOFF;
            end
            CS_GOFF: begin
                if (irq)                         state_d = CS_GON;
                else if (pg_ack || step_end)     state_d = CS_C6;
            end
            CS_C6:   if (irq && unc_ready)             state_d = CS_GON;
            CS_GON:  if (pg_ack || step_end)           state_d = CS_REST;
            CS_REST: if (restore_done || step_end)     state_d = CS_ACT;
            default: state_d = CS_ACT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_ACT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= '0;
            else if (!step_end)     cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        run = 1'b0; clk_most_en = 1'b0; clk_rest_en = 1'b0;
        pwr_en = 1'b1; save_req = 1'b0; restore_req = 1'b0;
        unique case (state_q)
            CS_ACT:  begin run = 1'b1; clk_most_en = 1'b1; clk_rest_en = 1'b1; end
            CS_C1:   clk_rest_en = 1'b1;
            CS_C3:   ;
            CS_SAVE: begin clk_most_en = 1'b1; clk_rest_en = 1'b1; save_req = 1'b1; end
            CS_GOFF: pwr_en = 1'b0;
            CS_C6:   pwr_en = 1'b0;
            CS_GON:  ;
            CS_REST: begin clk_most_en = 1'b1; clk_rest_en = 1'b1; restore_req = 1'b1; end
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/idle_pkg_seq.sv
module idle_pkg_seq
    import idle_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic all_gated,
    input  logic any_irq,
    output logic unc_ready,
    output logic unc_act_en,
    output logic io_lp,
    output logic unc_clk_en,
    output logic deep
);
    pkg_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PK_RUN:  if (all_gated && !any_irq) st_d = PK_DEEP;
            PK_DEEP: if (any_irq)               st_d = PK_WAKE;
            PK_WAKE: st_d = PK_RUN;
            default: st_d = PK_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PK_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        unc_act_en = 1'b1; io_lp = 1'b0; unc_clk_en = 1'b1; deep = 1'b0;
        unique case (st_q)
            PK_RUN:  ;
            PK_WAKE: unc_act_en = 1'b0;
            PK_DEEP: begin unc_act_en = 1'b0; io_lp = 1'b1; unc_clk_en = 1'b0; deep = 1'b1; end
            default: ;
        endcase
    end

    assign unc_ready = (st_q == PK_RUN);
endmodule

// File: rtl/idle_ctrl.sv
module idle_ctrl
    import idle_pkg::*;
#(
    parameter int N  = 4,
    parameter int TW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW-1:0]   tmo_lim,
    input  logic [N-1:0]    idle_req,
    input  logic [2*N-1:0]  idle_depth,
    input  logic [N-1:0]    irq,
    input  logic [N-1:0]    save_done,
    input  logic [N-1:0]    restore_done,
    input  logic [N-1:0]    pg_ack,
    output logic [3*N-1:0]  core_state,
    output logic [N-1:0]    core_run,
    output logic [N-1:0]    clk_most_en,
    output logic [N-1:0]    clk_rest_en,
    output logic [N-1:0]    pwr_en,
    output logic [N-1:0]    save_req,
    output logic [N-1:0]    restore_req,
    output logic            unc_act_en,
    output logic            io_lp,
    output logic            unc_clk_en,
    output logic            pkg_deep
);
    localparam int SW = $bits(core_st_e);

    logic [N-1:0] gated;
    logic         unc_ready;

    for (genvar gi = 0; gi < N; gi++) begin : g_core
        core_st_e st;
        idle_core_seq #(.TW(TW)) u_seq (
            .clk          (clk),
            .rst_n        (rst_n),
            .req          (idle_req[gi]),
            .depth        (idle_depth[2*gi +: 2]),
            .irq          (irq[gi]),
            .unc_ready    (unc_ready),
            .save_done    (save_done[gi]),
            .restore_done (restore_done[gi]),
            .pg_ack       (pg_ack[gi]),
            .tmo_lim      (tmo_lim),
            .state        (st),
            .run          (core_run[gi]),
            .clk_most_en  (clk_most_en[gi]),
            .clk_rest_en  (clk_rest_en[gi]),
            .pwr_en       (pwr_en[gi]),
            .save_req     (save_req[gi]),
            .restore_req  (restore_req[gi])
        );
        assign core_state[SW*gi +: SW] = st;
        assign gated[gi] = (st == CS_C6);
    end

    idle_pkg_seq u_pkg (
        .clk        (clk),
        .rst_n      (rst_n),
        .all_gated  (&gated),
        .any_irq    (|irq),
        .unc_ready  (unc_ready),
        .unc_act_en (unc_act_en),
        .io_lp      (io_lp),
        .unc_clk_en (unc_clk_en),
        .deep       (pkg_deep)
    );
endmodule

// File: rtl/idle_ctrl_chk.sv
module idle_ctrl_chk #(
    parameter int N  = 4,
    parameter int TW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [TW-1:0]   tmo_lim,
    input logic [N-1:0]    idle_req,
    input logic [2*N-1:0]  idle_depth,
    input logic [N-1:0]    irq,
    input logic [N-1:0]    save_done,
    input logic [N-1:0]    restore_done,
    input logic [N-1:0]    pg_ack,
    input logic [3*N-1:0]  core_state,
    input logic [N-1:0]    core_run,
    input logic [N-1:0]    clk_most_en,
    input logic [N-1:0]    clk_rest_en,
    input logic [N-1:0]    pwr_en,
    input logic [N-1:0]    save_req,
    input logic [N-1:0]    restore_req,
    input logic            unc_act_en,
    input logic            io_lp,
    input logic            unc_clk_en,
    input logic            pkg_deep
);
    for (genvar gi = 0; gi < N; gi++) begin : g_c
        p_pwr_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !pwr_en[gi] |-> (!clk_most_en[gi] && !clk_rest_en[gi]));

        p_run_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
            core_run[gi] |-> (clk_most_en[gi] && clk_rest_en[gi] && pwr_en[gi]));

        p_hs_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(save_req[gi] && restore_req[gi]));

        p_c6_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(core_state[3*gi +: 3]) == 3'd5 && core_state[3*gi +: 3] != 3'd5)
            |-> $past(unc_act_en));

        p_gon_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (core_state[3*gi +: 3] == 3'd6 && $past(core_state[3*gi +: 3]) != 3'd6)
            |-> ($past(core_state[3*gi +: 3]) == 3'd5 || $past(core_state[3*gi +: 3]) == 3'd4));

        p_deep_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
            pkg_deep |-> core_state[3*gi +: 3] == 3'd5);
    end

    p_wake_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pkg_deep) |-> (unc_clk_en && !io_lp && !unc_act_en));
endmodule

bind idle_ctrl idle_ctrl_chk #(.N(N), .TW(TW)) u_chk (.*);

// File: tb/idle_ctrl_bench.sv
`timescale 1ns/1ps
module idle_ctrl_bench;
    localparam int N  = 3;
    localparam int TW = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [TW-1:0]   tmo_lim;
    logic [N-1:0]    idle_req, irq, save_done, restore_done, pg_ack;
    logic [2*N-1:0]  idle_depth;
    logic [3*N-1:0]  core_state;
    logic [N-1:0]    core_run, clk_most_en, clk_rest_en, pwr_en, save_req, restore_req;
    logic            unc_act_en, io_lp, unc_clk_en, pkg_deep;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    idle_ctrl #(.N(N), .TW(TW)) u_idle_ctrl (.*);

    function automatic int st(input int c);
        return int'(core_state[3*c +: 3]);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic dwell(input int c, input int code, output int n);
        n = 0;
        while (st(c) == code && n < 40) begin
            n++;
            tick();
        end
    endtask

    task automatic request(input int c, input int d);
        idle_req[c] = 1'b1;
        idle_depth[2*c +: 2] = 2'(d);
        tick();
        idle_req[c] = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n;
        rst_n = 1'b0; tmo_lim = '0; idle_req = '0; irq = '0;
        save_done = '0; restore_done = '0; pg_ack = '0; idle_depth = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        for (int c = 0; c < N; c++) chk("R1 state", st(c), 0);
        chk("R1 core outputs", int'({core_run, clk_most_en, clk_rest_en, pwr_en}), (1 << (4*N)) - 1);
        chk("R1 package", int'({unc_act_en, io_lp, unc_clk_en, pkg_deep}), 4'b1010);

        // R2 / R4 / R7 sweep over cores and shallow depths
        for (int c = 0; c < N; c++) begin
            for (int d = 0; d < 3; d++) begin
                request(c, d);
                chk("R2 depth state", st(c), d);
                chk("R2 run", int'(core_run[c]), (d == 0) ? 1 : 0);
                chk("R2 main clk", int'(clk_most_en[c]), (d == 0) ? 1 : 0);
                chk("R2 rest clk", int'(clk_rest_en[c]), (d == 2) ? 0 : 1);
                for (int o = 0; o < N; o++)
                    if (o != c) chk("R7 other core", st(o) * 2 + int'(core_run[o]), 1);
                if (d != 0) begin
                    request(c, 3 - d);
                    chk("R2 ignored when idle", st(c), d);
                end
                irq[c] = 1'b1;
                tick();
                irq[c] = 1'b0;
                chk("R4 irq wake", st(c), 0);
            end
            irq[c] = 1'b1;
            request(c, 2);
            irq[c] = 1'b0;
            chk("R2 request with irq ignored", st(c), 0);
        end

        // R10 / R3 / R5 timeout sweep on core 0
        for (int lim = 0; lim < 4; lim++) begin
            tmo_lim = TW'(lim);
            request(0, 3);
            chk("R3 saving", st(0), 3);
            chk("R3 save req clocks", int'({save_req[0], clk_most_en[0], pwr_en[0]}), 7);
            dwell(0, 3, n);
            chk("R10 save dwell", n, lim + 1);
            chk("R3 gating", st(0), 4);
            chk("R3 gating outputs", int'({pwr_en[0], clk_most_en[0], clk_rest_en[0]}), 0);
            dwell(0, 4, n);
            chk("R10 gate dwell", n, lim + 1);
            chk("R3 gated", st(0), 5);
            chk("R7 core1 running", int'(core_run[1]), 1);
            irq[0] = 1'b1;
            tick();
            chk("R5 ungating", st(0), 6);
            chk("R5 ungating outputs", int'({pwr_en[0], clk_most_en[0]}), 2);
            dwell(0, 6, n);
            chk("R10 ungate dwell", n, lim + 1);
            chk("R5 restoring", int'({st(0), restore_req[0], clk_most_en[0]}), 7 * 4 + 3);
            dwell(0, 7, n);
            chk("R10 restore dwell", n, lim + 1);
            irq[0] = 1'b0;
            chk("R5 back active", int'({st(0), core_run[0]}), 1);
        end

        // R3 handshake-driven steps
        tmo_lim = 4'd15;
        save_done[0] = 1'b1; pg_ack[0] = 1'b1; restore_done[0] = 1'b1;
        request(0, 3);
        chk("R3 hs save", st(0), 3);
        tick(); chk("R3 hs gate", st(0), 4);
        tick(); chk("R3 hs gated", st(0), 5);
        irq[0] = 1'b1;
        tick(); chk("R5 hs ungate", st(0), 6);
        tick(); chk("R5 hs restore", st(0), 7);
        tick(); chk("R5 hs active", st(0), 0);
        irq[0] = 1'b0; save_done = '0; pg_ack = '0; restore_done = '0;

        // R6 aborts
        tmo_lim = 4'd5;
        request(0, 3);
        irq[0] = 1'b1;
        tick();
        irq[0] = 1'b0;
        chk("R6 abort in save", st(0), 0);
        request(0, 3);
        dwell(0, 3, n);
        chk("R6 reached gating", st(0), 4);
        irq[0] = 1'b1;
        tick();
        chk("R6 abort in gating", st(0), 6);
        dwell(0, 6, n);
        dwell(0, 7, n);
        irq[0] = 1'b0;
        chk("R6 abort done", st(0), 0);

        // R8 / R9 package sequence
        tmo_lim = '0;
        save_done = '1; pg_ack = '1; restore_done = '1;
        for (int c = 0; c < N; c++) begin
            request(c, 3);
            tick(); tick();
            chk("R3 core gated", st(c), 5);
            chk("R8 not deep yet", int'({pkg_deep, unc_act_en}), 1);
        end
        tick();
        chk("R8 deep outputs", int'({pkg_deep, unc_act_en, io_lp, unc_clk_en}), 4'b1010);
        irq[1] = 1'b1;
        tick();
        chk("R9 wake outputs", int'({pkg_deep, unc_act_en, io_lp, unc_clk_en}), 4'b0001);
        chk("R9 core held in wake", st(1), 5);
        tick();
        chk("R9 run restored", int'(unc_act_en), 1);
        chk("R9 core held until run", st(1), 5);
        tick();
        chk("R9 core ungating", st(1), 6);
        chk("R7 core0 stays gated", st(0), 5);
        chk("R7 core2 stays gated", st(2), 5);
        tick(); tick();
        chk("R9 core active", st(1), 0);
        irq[1] = 1'b0;
        irq = '1;
        tick(); tick(); tick();
        irq = '0;
        for (int c = 0; c < N; c++) chk("R5 all active", st(c), 0);
        tick();
        chk("R8 package running", int'({pkg_deep, unc_act_en}), 1);

        finish_run();
    end
endmodule